// File: doc/BRIEF.md
# Serial Register Access Port

This block is the slave end of a serial control link. An external host drives a serial clock, an active-low select and a data line, and through them reads and writes byte registers in an address space from 0x000 to 0x232. Each access opens with a 16-bit command word: a direction flag, a two-bit length code and a 13-bit start address. Then come one, two or three data bytes, or an open-ended stream. The port turns each completed write byte into a one-cycle write strobe toward a register bank. For reads it fetches bytes through a combinational read bus and shifts them back to the host.

The pin inputs are brought into the system clock domain through synchronizers, and the serial clock edges are found there. Data is captured on rising serial clock edges and read data is launched on falling ones. The port itself holds the register at address 0x000. That register picks the bit order (most significant first by default, or least significant first) and the readback wiring (shared data line by default, or a separate output line). A new setting applies from the next bit, with no separate update command. The bit order also fixes the address direction: it counts down when the most significant bit goes first and counts up otherwise.

Top module: `sctl_port`

## Requirements
- R1: The command word is 16 bits wide. Its bit 15 is the direction (1 = read, 0 = write), bits 14:13 are the length code and bits 12:0 are the start address. In the default order, bit 15 of the command word and bit 7 of each data byte are sent first.
- R2: Length codes 0, 1 and 2 transfer exactly 1, 2 and 3 bytes. Bytes the host sends after that are ignored and cause no write.
- R3: Length code 3 streams bytes until the select rises or the stop rule of R4/R5 ends the stream.
- R4: In the default order the address decrements after each byte, and from 0x000 it wraps to 0x232. The access ends after the byte at 0x232, so a stream from 0x001 covers 0x001, 0x000, 0x232 and nothing more. Once the access ends, no output is enabled.
- R5: When bits 6 and 1 of register 0x000 are both set, bits travel least significant first and the address increments after each byte. The access ends after the byte at 0x232.
- R6: Each completed write byte to an address from 0x001 to 0x232 gives a single-cycle regWrEn, with regAddr and regWrData carrying that address and byte.
- R7: An address above 0x232, or any address with bits 12:10 not all zero, reads back as 0x00 and never produces regWrEn.
- R8: In shared-line mode, a read drives sdioOe high from the last command bit onward. Each data bit appears on sdioOut after a falling serial clock edge.
- R9: When bits 7 and 0 of register 0x000 are both set, read data appears on sdoOut with sdoOe high and sdioOe stays low. The two enables are never high together.
- R10: Register 0x000 resets to 0x18 (default order, shared line). It is written and read through the port at address 0x000 and is never passed to the bank.
- R11: A rising select at any point ends the access, clears the bit and byte counts and drops both output enables. A partial command leaves nothing behind that affects the next access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sclkIn | input | 1 | Serial clock from host |
| csNIn | input | 1 | Active-low select from host |
| sdioIn | input | 1 | Serial data from host on the shared line |
| sdioOut | output | 1 | Read data toward the shared line |
| sdioOe | output | 1 | Drive enable for the shared line |
| sdoOut | output | 1 | Read data toward the separate output line |
| sdoOe | output | 1 | Drive enable for the separate output line |
| regAddr | output | 10 | Bank address for a read, or for the write being strobed |
| regWrData | output | 8 | Byte to write |
| regWrEn | output | 1 | Single-cycle write strobe |
| regRdData | input | 8 | Bank byte at regAddr |

## Verification
The hardest case to reach is the end of a descending stream: the address has to fall through 0x000, wrap to 0x232 and stop. The bench reaches it by starting a streaming read at 0x001 and clocking a fourth byte. It expects the bank byte, the port's own configuration byte, the bank byte at 0x232, and then a released line. The ascending stop and the separate-line readback are only reachable after the port has reprogrammed itself, so the bench first writes mirrored configuration values at address 0x000 and then runs those accesses in the new bit order.

// File: rtl/sctl_pkg.sv
package sctl_pkg;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_INSTR,
    PH_DATA,
    PH_DONE
  } phase_t;

  // Strobes from control to datapath, one cycle each
  typedef struct packed {
    logic       clear;
    logic       sample;
    logic       instrDone;
    logic       byteDone;
    logic       launch;
    logic [2:0] bitIdx;
  } strobe_t;

endpackage

// File: rtl/sctl_ctrl.sv
module sctl_ctrl
  import sctl_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int INSTR_BITS  = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclkIn,
  input  logic       csNIn,
  input  logic       sdioIn,
  input  logic       rdFlag,
  input  logic [1:0] lenCode,
  input  logic       atStop,
  output strobe_t    strb,
  output logic       rxBit,
  output phase_t     phase,
  output logic       csActive
);

  localparam int CNT_W = $clog2(INSTR_BITS);
  localparam logic [CNT_W-1:0] INSTR_LAST = CNT_W'(INSTR_BITS - 1);
  localparam logic [CNT_W-1:0] BYTE_LAST  = CNT_W'(7);

  logic [SYNC_STAGES-1:0] sclkQ, csQ, sdQ;
  logic                   sclkPrev;
  logic [CNT_W-1:0]       bitCnt;
  logic [1:0]             byteCnt;
  logic                   sclkRise, sclkFall, sclkNow;

  // Synchronizer chains, one stage per generate step
  for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          sclkQ[0] <= 1'b0;
          csQ[0]   <= 1'b1;
          sdQ[0]   <= 1'b0;
        end else begin
          sclkQ[0] <= sclkIn;
          csQ[0]   <= csNIn;
          sdQ[0]   <= sdioIn;
        end
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          sclkQ[s] <= 1'b0;
          csQ[s]   <= 1'b1;
          sdQ[s]   <= 1'b0;
        end else begin
          sclkQ[s] <= sclkQ[s-1];
          csQ[s]   <= csQ[s-1];
          sdQ[s]   <= sdQ[s-1];
        end
      end
    end
  end

  assign sclkNow  = sclkQ[SYNC_STAGES-1];
  assign csActive = ~csQ[SYNC_STAGES-1];
  assign rxBit    = sdQ[SYNC_STAGES-1];
  assign sclkRise = sclkNow & ~sclkPrev;
  assign sclkFall = ~sclkNow & sclkPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkPrev <= 1'b0;
      phase    <= PH_IDLE;
      bitCnt   <= '0;
      byteCnt  <= '0;
    end else begin
      sclkPrev <= sclkNow;
      if (!csActive) begin
        phase   <= PH_IDLE;
        bitCnt  <= '0;
        byteCnt <= '0;
      end else begin
        unique case (phase)
          PH_IDLE: begin
            phase  <= PH_INSTR;
            bitCnt <= '0;
          end
          PH_INSTR: if (sclkRise) begin
            if (bitCnt == INSTR_LAST) begin
              phase  <= PH_DATA;
              bitCnt <= '0;
            end else begin
              bitCnt <= bitCnt + 1'b1;
            end
          end
          PH_DATA: if (sclkRise) begin
            if (bitCnt == BYTE_LAST) begin
              bitCnt  <= '0;
              byteCnt <= byteCnt + 1'b1;
              if (atStop || (lenCode != 2'd3 && byteCnt == lenCode))
                phase <= PH_DONE;
            end else begin
              bitCnt <= bitCnt + 1'b1;
            end
          end
          default: phase <= PH_DONE;
        endcase
      end
    end
  end

  always_comb begin
    strb.clear     = ~csActive;
    strb.sample    = sclkRise && (phase == PH_INSTR || phase == PH_DATA);
    strb.instrDone = sclkRise && phase == PH_INSTR && bitCnt == INSTR_LAST;
    strb.byteDone  = sclkRise && phase == PH_DATA && bitCnt == BYTE_LAST;
    strb.launch    = sclkFall && phase == PH_DATA && rdFlag;
    strb.bitIdx    = bitCnt[2:0];
  end

endmodule

// File: rtl/sctl_dpath.sv
module sctl_dpath
  import sctl_pkg::*;
#(
  parameter int          ADDR_W    = 13,
  parameter int          REG_AW    = 10,
  parameter int          MAX_ADDR  = 'h232,
  parameter logic [7:0]  CFG_RESET = 8'h18
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic              rxBit,
  input  logic [7:0]        regRdData,
  output logic [REG_AW-1:0] regAddr,
  output logic [7:0]        regWrData,
  output logic              regWrEn,
  output logic              rdFlag,
  output logic [1:0]        lenCode,
  output logic              atStop,
  output logic              unidir,
  output logic              txBit
);

  localparam int IW = ADDR_W + 3;
  localparam logic [ADDR_W-1:0] MAX_A = ADDR_W'(MAX_ADDR);

  logic [IW-1:0]     shiftReg, nextShift;
  logic [ADDR_W-1:0] curAddr, nextAddr;
  logic [REG_AW-1:0] wrAddr;
  logic [7:0]        cfgReg, holdByte, rxByte, rdByte, txSrc;
  logic              lsbFirst, inRange, isCfg;

  assign lsbFirst = cfgReg[6] & cfgReg[1];
  assign unidir   = cfgReg[7] & cfgReg[0];
  assign inRange  = curAddr <= MAX_A;
  assign isCfg    = curAddr == '0;
  assign atStop   = curAddr == MAX_A;

  always_comb begin
    nextShift = lsbFirst ? {rxBit, shiftReg[IW-1:1]} : {shiftReg[IW-2:0], rxBit};
    rxByte    = lsbFirst ? nextShift[IW-1 -: 8] : nextShift[7:0];
    if (lsbFirst)          nextAddr = curAddr + ADDR_W'(1);
    else if (isCfg)        nextAddr = MAX_A;
    else                   nextAddr = curAddr - ADDR_W'(1);
    if (isCfg)             rdByte = cfgReg;
    else if (inRange)      rdByte = regRdData;
    else                   rdByte = '0;
    txSrc = (strb.bitIdx == 3'd0) ? rdByte : holdByte;
  end

  assign regAddr = regWrEn ? wrAddr : curAddr[REG_AW-1:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg  <= '0;
      curAddr   <= '0;
      wrAddr    <= '0;
      cfgReg    <= CFG_RESET;
      holdByte  <= '0;
      regWrData <= '0;
      regWrEn   <= 1'b0;
      rdFlag    <= 1'b0;
      lenCode   <= '0;
      txBit     <= 1'b0;
    end else begin
      regWrEn <= 1'b0;
      if (strb.clear) begin
        shiftReg <= '0;
        rdFlag   <= 1'b0;
      end else begin
        if (strb.sample) shiftReg <= nextShift;
        if (strb.instrDone) begin
          rdFlag  <= nextShift[IW-1];
          lenCode <= nextShift[IW-2 -: 2];
          curAddr <= nextShift[ADDR_W-1:0];
        end
        if (strb.byteDone) begin
          if (!rdFlag) begin
            if (isCfg) begin
              cfgReg <= rxByte;
            end else if (inRange) begin
              regWrEn   <= 1'b1;
              regWrData <= rxByte;
              wrAddr    <= curAddr[REG_AW-1:0];
            end
          end
          curAddr <= nextAddr;
        end
        if (strb.launch) begin
          if (strb.bitIdx == 3'd0) holdByte <= rdByte;
          txBit <= lsbFirst ? txSrc[strb.bitIdx] : txSrc[3'd7 - strb.bitIdx];
        end
      end
    end
  end

endmodule

// File: rtl/sctl_port.sv
module sctl_port
  import sctl_pkg::*;
#(
  parameter int         SYNC_STAGES = 2,
  parameter int         ADDR_W      = 13,
  parameter int         REG_AW      = 10,
  parameter int         MAX_ADDR    = 'h232,
  parameter logic [7:0] CFG_RESET   = 8'h18
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclkIn,
  input  logic              csNIn,
  input  logic              sdioIn,
  output logic              sdioOut,
  output logic              sdioOe,
  output logic              sdoOut,
  output logic              sdoOe,
  output logic [REG_AW-1:0] regAddr,
  output logic [7:0]        regWrData,
  output logic              regWrEn,
  input  logic [7:0]        regRdData
);

  strobe_t    strb;
  phase_t     phase;
  logic       rxBit, rdFlag, atStop, unidir, txBit, csActive, readOut;
  logic [1:0] lenCode;

  sctl_ctrl #(
    .SYNC_STAGES(SYNC_STAGES),
    .INSTR_BITS (ADDR_W + 3)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .sclkIn  (sclkIn),
    .csNIn   (csNIn),
    .sdioIn  (sdioIn),
    .rdFlag  (rdFlag),
    .lenCode (lenCode),
    .atStop  (atStop),
    .strb    (strb),
    .rxBit   (rxBit),
    .phase   (phase),
    .csActive(csActive)
  );

  sctl_dpath #(
    .ADDR_W   (ADDR_W),
    .REG_AW   (REG_AW),
    .MAX_ADDR (MAX_ADDR),
    .CFG_RESET(CFG_RESET)
  ) u_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .rxBit    (rxBit),
    .regRdData(regRdData),
    .regAddr  (regAddr),
    .regWrData(regWrData),
    .regWrEn  (regWrEn),
    .rdFlag   (rdFlag),
    .lenCode  (lenCode),
    .atStop   (atStop),
    .unidir   (unidir),
    .txBit    (txBit)
  );

  assign readOut = csActive && phase == PH_DATA && rdFlag;
  assign sdioOe  = readOut && !unidir;
  assign sdoOe   = readOut && unidir;
  assign sdioOut = txBit;
  assign sdoOut  = txBit;

endmodule

// File: rtl/sctl_port_chk.sv
module sctl_port_chk #(
  parameter int REG_AW   = 10,
  parameter int MAX_ADDR = 'h232
) (
  input logic              clk,
  input logic              rstN,
  input logic              csActive,
  input logic              unidir,
  input logic              sdioOe,
  input logic              sdoOe,
  input logic              regWrEn,
  input logic [REG_AW-1:0] regAddr
);

  p_oe_exclusive_r9: assert property (@(posedge clk) disable iff (!rstN)
    !(sdioOe && sdoOe));

  p_unidir_quiet_r9: assert property (@(posedge clk) disable iff (!rstN)
    unidir |-> !sdioOe);

  p_idle_release_r11: assert property (@(posedge clk) disable iff (!rstN)
    !csActive |-> (!sdioOe && !sdoOe));

  p_wr_single_r6: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn |=> !regWrEn);

  p_wr_range_r7: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn |-> (regAddr != '0 && int'(regAddr) <= MAX_ADDR));

endmodule

bind sctl_port sctl_port_chk #(
  .REG_AW  (REG_AW),
  .MAX_ADDR(MAX_ADDR)
) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .csActive(csActive),
  .unidir  (unidir),
  .sdioOe  (sdioOe),
  .sdoOe   (sdoOe),
  .regWrEn (regWrEn),
  .regAddr (regAddr)
);

// File: tb/sctl_port_test.sv
module sctl_port_test;

  localparam int HALF  = 8;
  localparam int LIMIT = 150000;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       sclkIn = 1'b0;
  logic       csNIn = 1'b1;
  logic       sdioIn = 1'b0;
  logic       sdioOut, sdioOe, sdoOut, sdoOe, regWrEn;
  logic [9:0] regAddr;
  logic [7:0] regWrData, regRdData;

  logic [7:0] bank [0:1023];
  logic [9:0] logAddr [0:63];
  logic [7:0] logData [0:63];
  int logCnt = 0;
  int sdioOeCnt = 0;
  int nChk = 0;
  int nFail = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  sctl_port uut (
    .clk(clk), .rstN(rstN), .sclkIn(sclkIn), .csNIn(csNIn), .sdioIn(sdioIn),
    .sdioOut(sdioOut), .sdioOe(sdioOe), .sdoOut(sdoOut), .sdoOe(sdoOe),
    .regAddr(regAddr), .regWrData(regWrData), .regWrEn(regWrEn),
    .regRdData(regRdData)
  );

  function automatic logic [7:0] initVal(int a);
    return 8'(a) ^ 8'h3C;
  endfunction

  // Register bank model and write log
  assign regRdData = bank[regAddr];
  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < 1024; i++) bank[i] <= initVal(i);
    end else if (regWrEn) begin
      bank[regAddr] <= regWrData;
      logAddr[logCnt % 64] <= regAddr;
      logData[logCnt % 64] <= regWrData;
      logCnt <= logCnt + 1;
    end
  end

  always @(negedge clk) if (sdioOe) sdioOeCnt <= sdioOeCnt + 1;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp, string what);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic waitHalf();
    repeat (HALF) @(negedge clk);
  endtask

  task automatic clockBit(logic b);
    sdioIn = b;
    waitHalf();
    sclkIn = 1'b1;
    waitHalf();
    sclkIn = 1'b0;
  endtask

  // One access: command, then nb bytes, capturing readback
  task automatic xfer(input bit lsb, input bit rd, input logic [1:0] len,
                      input logic [12:0] addr, input int nb,
                      input logic [47:0] wbytes, input bit fourWire,
                      output logic [47:0] rbytes);
    logic [15:0] w;
    w = {rd, len, addr};
    rbytes = '0;
    csNIn = 1'b0;
    waitHalf();
    for (int i = 0; i < 16; i++) clockBit(lsb ? w[i] : w[15 - i]);
    for (int k = 0; k < nb; k++) begin
      for (int j = 0; j < 8; j++) begin
        int idx;
        logic o, oe;
        idx = lsb ? j : 7 - j;
        sdioIn = wbytes[8*k + idx];
        waitHalf();
        o  = fourWire ? sdoOut : sdioOut;
        oe = fourWire ? sdoOe : sdioOe;
        rbytes[8*k + idx] = oe ? o : 1'bx;
        sclkIn = 1'b1;
        waitHalf();
        sclkIn = 1'b0;
      end
    end
    waitHalf();
    csNIn = 1'b1;
    repeat (4 * HALF) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [47:0] r;
    check("R10", {29'd0, sdioOe, sdoOe, regWrEn}, 32'd0, "outputs idle after reset");
    xfer(0, 1, 2'd0, 13'h000, 1, '0, 0, r);
    check("R10", r[7:0], 8'h18, "config reset value");
  endtask

  task automatic t_single_write();
    logic [47:0] r;
    int base = logCnt;
    xfer(0, 0, 2'd0, 13'h010, 1, 48'hA5, 0, r);
    check("R6", logCnt - base, 1, "single write count");
    check("R1", logAddr[base % 64], 10'h010, "single write address");
    check("R1", logData[base % 64], 8'hA5, "single write data");
  endtask

  task automatic t_multi_write();
    logic [47:0] r;
    int base = logCnt;
    xfer(0, 0, 2'd2, 13'h020, 4, 48'h44332211, 0, r);
    check("R2", logCnt - base, 3, "three-byte count, extra byte ignored");
    check("R4", logAddr[(base + 2) % 64], 10'h01E, "decrementing address");
    check("R2", logData[(base + 2) % 64], 8'h33, "third byte data");
    base = logCnt;
    xfer(0, 0, 2'd3, 13'h100, 2, 48'hBBAA, 0, r);
    check("R3", logCnt - base, 2, "stream ended by select");
    check("R3", logAddr[(base + 1) % 64], 10'h0FF, "stream second address");
  endtask

  task automatic t_read_back();
    logic [47:0] r;
    xfer(0, 1, 2'd1, 13'h020, 2, '0, 0, r);
    check("R8", r[15:0], 16'h2211, "two-byte readback on shared line");
  endtask

  task automatic t_wrap_stream();
    logic [47:0] r;
    xfer(0, 1, 2'd3, 13'h001, 4, '0, 0, r);
    check("R4", r[7:0], initVal(1), "stream byte at 0x001");
    check("R4", r[15:8], 8'h18, "stream byte at 0x000");
    check("R4", r[23:16], initVal('h232), "stream wraps to 0x232");
    check("R4", {24'd0, r[31:24]}, {24'd0, 8'bx}, "released after stop");
  endtask

  task automatic t_out_of_range();
    logic [47:0] r;
    int base = logCnt;
    xfer(0, 0, 2'd0, 13'h300, 1, 48'h5E, 0, r);
    xfer(0, 0, 2'd0, 13'h1010, 1, 48'h5F, 0, r);
    check("R7", logCnt - base, 0, "no write outside range");
    xfer(0, 1, 2'd0, 13'h300, 1, '0, 0, r);
    check("R7", r[7:0], 8'h00, "read outside range is zero");
    xfer(0, 1, 2'd0, 13'h010, 1, '0, 0, r);
    check("R7", r[7:0], 8'hA5, "upper-bit write left 0x010 alone");
  endtask

  task automatic t_cs_abort();
    logic [47:0] r;
    int base;
    csNIn = 1'b0;
    waitHalf();
    for (int i = 0; i < 9; i++) clockBit(1'b1);
    csNIn = 1'b1;
    repeat (4 * HALF) @(negedge clk);
    check("R11", {30'd0, sdioOe, sdoOe}, 32'd0, "outputs released after abort");
    base = logCnt;
    xfer(0, 0, 2'd0, 13'h040, 1, 48'h77, 0, r);
    check("R11", logCnt - base, 1, "write after abort count");
    check("R11", logAddr[base % 64], 10'h040, "write after abort address");
  endtask

  task automatic t_lsb_mode();
    logic [47:0] r;
    int base;
    xfer(0, 0, 2'd0, 13'h000, 1, 48'h5A, 0, r);
    xfer(1, 1, 2'd0, 13'h000, 1, '0, 0, r);
    check("R10", r[7:0], 8'h5A, "config readback in new order");
    base = logCnt;
    xfer(1, 0, 2'd3, 13'h230, 4, 48'h04030201, 0, r);
    check("R5", logCnt - base, 3, "ascending stream stops at 0x232");
    check("R5", logAddr[(base + 2) % 64], 10'h232, "last ascending address");
    check("R3", logData[(base + 2) % 64], 8'h03, "third stream byte");
    xfer(1, 1, 2'd1, 13'h230, 2, '0, 0, r);
    check("R5", r[15:0], 16'h0201, "ascending readback");
  endtask

  task automatic t_four_wire();
    logic [47:0] r;
    int base;
    xfer(1, 0, 2'd0, 13'h000, 1, 48'hDB, 0, r);
    base = sdioOeCnt;
    xfer(1, 1, 2'd0, 13'h231, 1, '0, 1, r);
    check("R9", r[7:0], 8'h02, "readback on separate line");
    check("R9", sdioOeCnt - base, 0, "shared line never driven");
    xfer(1, 0, 2'd0, 13'h000, 1, 48'h18, 1, r);
    xfer(0, 1, 2'd0, 13'h000, 1, '0, 0, r);
    check("R10", r[7:0], 8'h18, "default restored");
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_single_write();
    t_multi_write();
    t_read_back();
    t_wrap_stream();
    t_out_of_range();
    t_cs_abort();
    t_lsb_mode();
    t_four_wire();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
    $finish;
  end

  initial begin
    repeat (LIMIT) @(negedge clk);
    if (!finished) begin
      nChk++;
      nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
      $finish;
    end
  end

endmodule